// File: doc/BRIEF.md
# ADC Sample Streaming Bridge

The bridge sits between a free-running 10-bit parallel ADC and a 16-bit synchronous parallel bus that feeds a USB peripheral controller. On the sample clock it registers one offset-binary code per cycle and writes it into a dual-clock FIFO. On the bus clock, which runs at twice the sample rate, it reads the FIFO, removes the mid-scale code and a programmable DC trim, scales the result up to a 16-bit two's-complement word, and puts that word on the bus with a valid strobe whenever the consumer asserts ready. The consumer may stall for a while. The faster read side then drains the backlog once the consumer accepts data again.

Both clocks are forwarded out: the sample clock to the converter and the bus clock to the consumer, which uses it as its synchronous data clock. A capture-enable input gates the writes. A rising capture-enable starts a flush handshake across the clock boundary, so leftover samples from an earlier capture are discarded. A sample that arrives while the FIFO is full is lost, and that loss is recorded in a sticky overflow flag.

The write side runs a four-state machine. In `W_IDLE` the writer waits and no writes take place. It moves to `W_FLUSH` when the registered enable is high, and in doing so it toggles the flush request. In `W_FLUSH` it waits until the returned acknowledge matches the request, then moves to `W_SETTLE`. `W_SETTLE` lasts one cycle, while the read pointer that jumped settles through its synchronizer, and then goes to `W_RUN`, or back to `W_IDLE` if the enable has dropped. `W_RUN` writes one sample per cycle and returns to `W_IDLE` when the enable falls. The read side has two states. `R_STREAM` moves words to the bus and changes to `R_DROP` when a flush request is pending. `R_DROP` sets the read pointer equal to the synchronized write pointer, returns the acknowledge and goes back to `R_STREAM` on the next cycle.

Top module: `adc_stream_bridge`

## Requirements
- R1: Each streamed word equals ((code − 512 − trim) × 64) as a 16-bit two's-complement value. Here code is the 10-bit unsigned sample (0 is the lowest level, 512 is centre, 1023 is the highest) and trim is the signed 8-bit two's-complement trim register.
- R2: A result above 32767 is output as 32767, and a result below −32768 is output as −32768.
- R3: Every sample written into the FIFO appears on the bus exactly once, in capture order.
- R4: `bus_valid` is high in a bus cycle only if `cons_ready` was high and the FIFO held data at the preceding `bus_clk` rising edge. Data and valid change only on that edge.
- R5: The FIFO holds exactly DEPTH samples. A sample that arrives while it is full is dropped, and `overflow` is set.
- R6: `overflow` stays high until reset or a `ovf_clear` cycle. When a drop and a clear happen in the same cycle, the drop wins.
- R7: While `capture_en` is low, no sample is written, so nothing new reaches the bus.
- R8: When `capture_en` rises, every sample still held from the earlier capture is discarded before new samples are accepted. This holds provided the consumer does not take those samples in the few cycles the request needs to cross domains.
- R9: `adc_clk_out` follows `smp_clk` and `bus_clk_out` follows `bus_clk`.
- R10: After reset, `bus_valid` and `overflow` are low and the trim register is 0.
- R11: A trim value written with `trim_we` applies to every word converted after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| smp_clk | input | 1 | Sample clock (32 MHz) |
| smp_rst_n | input | 1 | Active-low asynchronous reset, sample domain |
| smp_code | input | 10 | Offset-binary ADC code |
| capture_en | input | 1 | Capture gate; a rising edge starts a flush |
| ovf_clear | input | 1 | Clears the sticky overflow flag |
| overflow | output | 1 | Sticky flag: a sample was dropped |
| adc_clk_out | output | 1 | Sample clock forwarded to the ADC |
| bus_clk | input | 1 | Bus clock (64 MHz) |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| trim_we | input | 1 | Loads `trim_val` into the trim register |
| trim_val | input | 8 | Signed DC trim, in codes |
| cons_ready | input | 1 | Consumer can accept a word |
| bus_valid | output | 1 | `bus_data` carries a new word this cycle |
| bus_data | output | 16 | Scaled signed sample |
| bus_clk_out | output | 1 | Bus clock forwarded to the consumer |

## Verification
The bench sweeps all 1024 codes under several trim values, including both trim extremes. This exposes a wrong sign extension of the trim, a missing clamp that would wrap near-full-scale codes to the opposite sign, and an off-by-one in the mid-scale code. One sweep uses a ready pattern with gaps. A handshake that ignored ready would then emit words during stalls, and a faulty Gray pointer would repeat or skip words. The FIFO is filled past DEPTH with ready held low. The bench checks that exactly DEPTH words come out and that overflow survives a clear that lands in a drop cycle. A flush test leaves marked samples behind, re-enables capture, and fails if any of those samples reach the bus.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    localparam int CODE_W   = 10;
    localparam int WORD_W   = 16;
    localparam int TRIM_W   = 8;
    localparam int SCALE_SH = 6;
    localparam int MID_CODE = 2 ** (CODE_W - 1);
    localparam int DIFF_W   = CODE_W + 3;
    localparam int SCALED_W = DIFF_W + SCALE_SH;
    localparam int WORD_MAX = 2 ** (WORD_W - 1) - 1;
    localparam int WORD_MIN = -(2 ** (WORD_W - 1));

    typedef enum logic [1:0] {
        W_IDLE,
        W_FLUSH,
        W_SETTLE,
        W_RUN
    } wr_state_t;

    typedef enum logic {
        R_STREAM,
        R_DROP
    } rd_state_t;

    // Centre, trim, scale, clamp.
    function automatic logic [WORD_W-1:0] to_word(
        input logic [CODE_W-1:0] code,
        input logic [TRIM_W-1:0] trim
    );
        logic signed [DIFF_W-1:0]   diff;
        logic signed [SCALED_W-1:0] scaled;
        diff = $signed({{(DIFF_W - CODE_W){1'b0}}, code})
             - $signed(DIFF_W'(MID_CODE))
             - $signed({{(DIFF_W - TRIM_W){trim[TRIM_W-1]}}, trim});
        scaled = $signed({{SCALE_SH{diff[DIFF_W-1]}}, diff}) <<< SCALE_SH;
        if (scaled > $signed(SCALED_W'(WORD_MAX)))
            return WORD_W'(WORD_MAX);
        else if (scaled < $signed(SCALED_W'(WORD_MIN)))
            return WORD_W'(WORD_MIN);
        else
            return scaled[WORD_W-1:0];
    endfunction

endpackage

// File: rtl/bridge_sync2.sv
module bridge_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/bridge_ram.sv
module bridge_ram #(
    parameter int AW = 12,
    parameter int W  = 10
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    localparam int ENTRIES = 2 ** AW;

    logic [W-1:0] mem [ENTRIES];

    always_ff @(posedge wclk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/bridge_wr_ctrl.sv
module bridge_wr_ctrl
    import bridge_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_en,
    input  logic [CODE_W-1:0] code_in,
    input  logic              ovf_clear,
    input  logic [AW:0]       rd_gray_sync,
    input  logic              ack_sync,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [CODE_W-1:0] wr_data,
    output logic [AW:0]       wr_gray,
    output logic              flush_req,
    output logic              full,
    output logic              overflow
);

    logic [CODE_W-1:0] code_q;
    logic              en_q;
    wr_state_t         state;
    wr_state_t         state_nx;
    logic [AW:0]       wr_bin;
    logic [AW:0]       wr_bin_nx;
    logic              drop;

    // Sample register: one code and one enable per cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            en_q   <= 1'b0;
        end else begin
            code_q <= code_in;
            en_q   <= capture_en;
        end
    end

    assign full      = (wr_gray == {~rd_gray_sync[AW:AW-1], rd_gray_sync[AW-2:0]});
    assign wr_en     = (state == W_RUN) && en_q && !full;
    assign drop      = (state == W_RUN) && en_q && full;
    assign wr_bin_nx = wr_bin + 1'b1;
    assign wr_addr   = wr_bin[AW-1:0];
    assign wr_data   = code_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= W_IDLE;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            W_IDLE:   if (en_q) state_nx = W_FLUSH;
            W_FLUSH:  if (ack_sync == flush_req) state_nx = W_SETTLE;
            W_SETTLE: state_nx = en_q ? W_RUN : W_IDLE;
            W_RUN:    if (!en_q) state_nx = W_IDLE;
            default:  state_nx = W_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_bin    <= '0;
            wr_gray   <= '0;
            flush_req <= 1'b0;
            overflow  <= 1'b0;
        end else begin
            if (state == W_IDLE && en_q)
                flush_req <= ~flush_req;
            if (wr_en) begin
                wr_bin  <= wr_bin_nx;
                wr_gray <= wr_bin_nx ^ (wr_bin_nx >> 1);
            end
            if (drop)
                overflow <= 1'b1;
            else if (ovf_clear)
                overflow <= 1'b0;
        end
    end

endmodule

// File: rtl/bridge_rd_ctrl.sv
module bridge_rd_ctrl
    import bridge_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ready,
    input  logic [AW:0]       wr_gray_sync,
    input  logic              req_sync,
    input  logic              trim_we,
    input  logic [TRIM_W-1:0] trim_val,
    input  logic [CODE_W-1:0] rd_code,
    output logic [AW-1:0]     rd_addr,
    output logic [AW:0]       rd_gray,
    output logic              flush_ack,
    output logic              empty,
    output logic              bus_valid,
    output logic [WORD_W-1:0] bus_data
);

    rd_state_t         state;
    rd_state_t         state_nx;
    logic [AW:0]       rd_bin;
    logic [AW:0]       rd_bin_nx;
    logic [AW:0]       wr_bin_sync;
    logic [TRIM_W-1:0] trim_q;
    logic              pending;
    logic              fire;

    always_comb begin
        for (int i = 0; i <= AW; i++)
            wr_bin_sync[i] = ^(wr_gray_sync >> i);
    end

    assign pending   = (req_sync != flush_ack);
    assign empty     = (rd_gray == wr_gray_sync);
    assign fire      = (state == R_STREAM) && !pending && !empty && ready;
    assign rd_bin_nx = rd_bin + 1'b1;
    assign rd_addr   = rd_bin[AW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= R_STREAM;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            R_STREAM: if (pending) state_nx = R_DROP;
            R_DROP:   state_nx = R_STREAM;
            default:  state_nx = R_STREAM;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_bin    <= '0;
            rd_gray   <= '0;
            flush_ack <= 1'b0;
            trim_q    <= '0;
            bus_valid <= 1'b0;
            bus_data  <= '0;
        end else begin
            if (trim_we)
                trim_q <= trim_val;
            bus_valid <= fire;
            if (fire) begin
                bus_data <= to_word(rd_code, trim_q);
                rd_bin   <= rd_bin_nx;
                rd_gray  <= rd_bin_nx ^ (rd_bin_nx >> 1);
            end
            if (state == R_DROP) begin
                rd_bin    <= wr_bin_sync;
                rd_gray   <= wr_gray_sync;
                flush_ack <= req_sync;
            end
        end
    end

endmodule

// File: rtl/adc_stream_bridge.sv
module adc_stream_bridge
    import bridge_pkg::*;
#(
    parameter int DEPTH = 4096
) (
    input  logic              smp_clk,
    input  logic              smp_rst_n,
    input  logic [CODE_W-1:0] smp_code,
    input  logic              capture_en,
    input  logic              ovf_clear,
    output logic              overflow,
    output logic              adc_clk_out,
    input  logic              bus_clk,
    input  logic              bus_rst_n,
    input  logic              trim_we,
    input  logic [TRIM_W-1:0] trim_val,
    input  logic              cons_ready,
    output logic              bus_valid,
    output logic [WORD_W-1:0] bus_data,
    output logic              bus_clk_out
);

    localparam int AW = $clog2(DEPTH);

    logic              wr_en;
    logic              wr_full;
    logic [AW-1:0]     wr_addr;
    logic [CODE_W-1:0] wr_data;
    logic [AW:0]       wr_gray;
    logic [AW:0]       wr_gray_bus;
    logic [AW:0]       rd_gray;
    logic [AW:0]       rd_gray_smp;
    logic [AW-1:0]     rd_addr;
    logic [CODE_W-1:0] rd_code;
    logic              rd_empty;
    logic              flush_req;
    logic              flush_req_bus;
    logic              flush_ack;
    logic              flush_ack_smp;

    assign adc_clk_out = smp_clk;
    assign bus_clk_out = bus_clk;

    bridge_wr_ctrl #(.AW(AW)) u_wr (
        .clk          (smp_clk),
        .rst_n        (smp_rst_n),
        .capture_en   (capture_en),
        .code_in      (smp_code),
        .ovf_clear    (ovf_clear),
        .rd_gray_sync (rd_gray_smp),
        .ack_sync     (flush_ack_smp),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .wr_gray      (wr_gray),
        .flush_req    (flush_req),
        .full         (wr_full),
        .overflow     (overflow)
    );

    bridge_ram #(.AW(AW), .W(CODE_W)) u_ram (
        .wclk  (smp_clk),
        .we    (wr_en),
        .waddr (wr_addr),
        .wdata (wr_data),
        .raddr (rd_addr),
        .rdata (rd_code)
    );

    bridge_sync2 #(.W(AW + 1)) u_wptr_sync (
        .clk (bus_clk), .rst_n (bus_rst_n), .d (wr_gray), .q (wr_gray_bus)
    );

    bridge_sync2 #(.W(AW + 1)) u_rptr_sync (
        .clk (smp_clk), .rst_n (smp_rst_n), .d (rd_gray), .q (rd_gray_smp)
    );

    bridge_sync2 #(.W(1)) u_req_sync (
        .clk (bus_clk), .rst_n (bus_rst_n), .d (flush_req), .q (flush_req_bus)
    );

    bridge_sync2 #(.W(1)) u_ack_sync (
        .clk (smp_clk), .rst_n (smp_rst_n), .d (flush_ack), .q (flush_ack_smp)
    );

    bridge_rd_ctrl #(.AW(AW)) u_rd (
        .clk          (bus_clk),
        .rst_n        (bus_rst_n),
        .ready        (cons_ready),
        .wr_gray_sync (wr_gray_bus),
        .req_sync     (flush_req_bus),
        .trim_we      (trim_we),
        .trim_val     (trim_val),
        .rd_code      (rd_code),
        .rd_addr      (rd_addr),
        .rd_gray      (rd_gray),
        .flush_ack    (flush_ack),
        .empty        (rd_empty),
        .bus_valid    (bus_valid),
        .bus_data     (bus_data)
    );

endmodule

// File: rtl/bridge_checker.sv
module bridge_checker (
    input logic smp_clk,
    input logic smp_rst_n,
    input logic bus_clk,
    input logic bus_rst_n,
    input logic capture_en,
    input logic ovf_clear,
    input logic overflow,
    input logic wr_en,
    input logic wr_full,
    input logic rd_empty,
    input logic cons_ready,
    input logic bus_valid
);

    // R5: no write lands in a full FIFO
    p_write_room_r5: assert property (@(posedge smp_clk) disable iff (!smp_rst_n)
        wr_en |-> !wr_full);

    // R5: overflow rises only out of a full FIFO
    p_ovf_from_full_r5: assert property (@(posedge smp_clk) disable iff (!smp_rst_n)
        $rose(overflow) |-> $past(wr_full));

    // R6: flag holds without a clear
    p_ovf_sticky_r6: assert property (@(posedge smp_clk) disable iff (!smp_rst_n)
        (overflow && !ovf_clear) |=> overflow);

    // R7: enable low stops writes one cycle later
    p_no_write_idle_r7: assert property (@(posedge smp_clk) disable iff (!smp_rst_n)
        !capture_en |=> !wr_en);

    // R4: a word goes out only after ready with data present
    p_valid_handshake_r4: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
        bus_valid |-> ($past(cons_ready) && !$past(rd_empty)));

endmodule

bind adc_stream_bridge bridge_checker u_bridge_chk (
    .smp_clk    (smp_clk),
    .smp_rst_n  (smp_rst_n),
    .bus_clk    (bus_clk),
    .bus_rst_n  (bus_rst_n),
    .capture_en (capture_en),
    .ovf_clear  (ovf_clear),
    .overflow   (overflow),
    .wr_en      (wr_en),
    .wr_full    (wr_full),
    .rd_empty   (rd_empty),
    .cons_ready (cons_ready),
    .bus_valid  (bus_valid)
);

// File: tb/tb_adc_stream_bridge.sv
module tb_adc_stream_bridge;

    localparam int BUS_PERIOD = 16;
    localparam int SMP_PERIOD = 2 * BUS_PERIOD;
    localparam int TB_DEPTH   = 16;
    localparam int RX_MAX     = 2048;
    localparam int FILL_CODE  = 512;
    localparam int FILL_CYC   = 12;

    logic       smp_clk = 1'b0;
    logic       bus_clk = 1'b0;
    logic       smp_rst_n = 1'b0;
    logic       bus_rst_n = 1'b0;
    logic [9:0] smp_code = '0;
    logic       capture_en = 1'b0;
    logic       ovf_clear = 1'b0;
    logic       overflow;
    logic       adc_clk_out;
    logic       trim_we = 1'b0;
    logic [7:0] trim_val = '0;
    logic       cons_ready = 1'b0;
    logic       bus_valid;
    logic [15:0] bus_data;
    logic       bus_clk_out;

    int n_tests = 0;
    int n_fail  = 0;
    int rx [RX_MAX];
    int rx_n = 0;
    int rdy_mode = 0;
    int rdy_cnt = 0;
    int cur_trim = 0;
    bit done = 1'b0;

    always #(BUS_PERIOD / 2) bus_clk = ~bus_clk;
    always #(SMP_PERIOD / 2) smp_clk = ~smp_clk;

    adc_stream_bridge #(.DEPTH(TB_DEPTH)) dut (
        .smp_clk     (smp_clk),
        .smp_rst_n   (smp_rst_n),
        .smp_code    (smp_code),
        .capture_en  (capture_en),
        .ovf_clear   (ovf_clear),
        .overflow    (overflow),
        .adc_clk_out (adc_clk_out),
        .bus_clk     (bus_clk),
        .bus_rst_n   (bus_rst_n),
        .trim_we     (trim_we),
        .trim_val    (trim_val),
        .cons_ready  (cons_ready),
        .bus_valid   (bus_valid),
        .bus_data    (bus_data),
        .bus_clk_out (bus_clk_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_word(input int code, input int trim);
        int v;
        v = (code - 512 - trim) * 64;
        if (v > 32767) v = 32767;
        if (v < -32768) v = -32768;
        return v;
    endfunction

    function automatic bit is_sat(input int code, input int trim);
        int v;
        v = (code - 512 - trim) * 64;
        return (v > 32767) || (v < -32768);
    endfunction

    // Monitor and ready driver in one process: sample, then drive next ready.
    always @(negedge bus_clk) begin
        if (bus_rst_n && bus_valid) begin
            chk(cons_ready == 1'b1, "R4 valid without ready", int'(cons_ready), 1);
            if (rx_n < RX_MAX) rx[rx_n] = int'($signed(bus_data));
            rx_n++;
        end
        rdy_cnt++;
        case (rdy_mode)
            0:       cons_ready = 1'b0;
            1:       cons_ready = 1'b1;
            default: cons_ready = ((rdy_cnt % 3) != 0);
        endcase
    end

    task automatic set_trim(input int t);
        @(negedge bus_clk);
        trim_we  = 1'b1;
        trim_val = 8'(t);
        @(negedge bus_clk);
        trim_we  = 1'b0;
        cur_trim = t;
    endtask

    task automatic drive_codes(input int first, input int n);
        for (int k = 0; k < n; k++) begin
            smp_code = 10'(first + k);
            @(negedge smp_clk);
        end
    endtask

    task automatic start_capture();
        @(negedge smp_clk);
        capture_en = 1'b1;
        smp_code   = 10'(FILL_CODE);
        repeat (FILL_CYC) @(negedge smp_clk);
    endtask

    task automatic stop_capture();
        capture_en = 1'b0;
        smp_code   = '0;
    endtask

    // Skip leading filler words, then expect consecutive codes.
    task automatic check_run(input int first, input int n, input string lbl);
        int i;
        i = 0;
        while (i < rx_n && rx[i] == exp_word(FILL_CODE, cur_trim)) i++;
        for (int k = 0; k < n; k++) begin
            if (i + k >= rx_n) begin
                chk(1'b0, {lbl, " R3 missing word"}, i + k, rx_n);
                break;
            end
            if (is_sat(first + k, cur_trim))
                chk(rx[i+k] == exp_word(first + k, cur_trim), {lbl, " R2 clamp"},
                    rx[i+k], exp_word(first + k, cur_trim));
            else
                chk(rx[i+k] == exp_word(first + k, cur_trim), {lbl, " R1 convert"},
                    rx[i+k], exp_word(first + k, cur_trim));
        end
        chk(rx_n == i + n, {lbl, " R3 word count"}, rx_n, i + n);
    endtask

    task automatic run_sweep(input bit wr_trim, input int t, input int mode, input string lbl);
        if (wr_trim) set_trim(t);
        rdy_mode = mode;
        rx_n = 0;
        start_capture();
        drive_codes(0, 1024);
        stop_capture();
        repeat (100) @(negedge smp_clk);
        check_run(0, 1024, lbl);
    endtask

    initial begin
        #(BUS_PERIOD * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int i;
        repeat (4) @(negedge smp_clk);
        chk(bus_valid == 1'b0, "R10 valid in reset", int'(bus_valid), 0);
        chk(overflow == 1'b0, "R10 overflow in reset", int'(overflow), 0);
        smp_rst_n = 1'b1;
        bus_rst_n = 1'b1;
        repeat (4) @(negedge smp_clk);
        chk(bus_valid == 1'b0, "R10 valid after reset", int'(bus_valid), 0);
        chk(overflow == 1'b0, "R10 overflow after reset", int'(overflow), 0);

        // R9: forwarded clocks
        for (int k = 0; k < 4; k++) begin
            #(BUS_PERIOD / 4);
            chk(adc_clk_out === smp_clk, "R9 adc clock", int'(adc_clk_out), int'(smp_clk));
            chk(bus_clk_out === bus_clk, "R9 bus clock", int'(bus_clk_out), int'(bus_clk));
        end

        // R10: trim left at its reset value of 0
        cur_trim = 0;
        run_sweep(1'b0, 0, 1, "R10 trim0");
        // R11: trim writes at both extremes and near zero
        run_sweep(1'b1, -128, 1, "R11 trim-128");
        run_sweep(1'b1, -1, 1, "R11 trim-1");
        run_sweep(1'b1, 1, 1, "R11 trim1");
        run_sweep(1'b1, 127, 1, "R11 trim127");
        // R4: gaps in ready
        run_sweep(1'b1, 5, 2, "R4 gapped");

        // R5 / R6: overfill with consumer stalled
        rdy_mode = 0;
        rx_n = 0;
        start_capture();
        drive_codes(100, 40);
        chk(overflow == 1'b1, "R5 overflow set", int'(overflow), 1);
        smp_code = 10'd200;
        ovf_clear = 1'b1;
        @(negedge smp_clk);
        ovf_clear = 1'b0;
        chk(overflow == 1'b1, "R6 drop beats clear", int'(overflow), 1);
        stop_capture();
        repeat (6) @(negedge smp_clk);
        chk(overflow == 1'b1, "R6 sticky", int'(overflow), 1);
        ovf_clear = 1'b1;
        @(negedge smp_clk);
        ovf_clear = 1'b0;
        chk(overflow == 1'b0, "R6 clear", int'(overflow), 0);
        rdy_mode = 1;
        repeat (60) @(negedge smp_clk);
        chk(rx_n == TB_DEPTH, "R5 depth", rx_n, TB_DEPTH);
        i = 0;
        while (i < rx_n && rx[i] == exp_word(FILL_CODE, cur_trim)) i++;
        for (int k = i; k < rx_n && k < RX_MAX; k++)
            chk(rx[k] == exp_word(100 + k - i, cur_trim), "R5 R3 kept order",
                rx[k], exp_word(100 + k - i, cur_trim));

        // R8: stale samples discarded on re-enable
        rdy_mode = 0;
        rx_n = 0;
        start_capture();
        drive_codes(900, 6);
        stop_capture();
        repeat (5) @(negedge smp_clk);
        start_capture();
        drive_codes(200, 6);
        stop_capture();
        repeat (5) @(negedge smp_clk);
        rdy_mode = 1;
        repeat (60) @(negedge smp_clk);
        check_run(200, 6, "R8 flush");
        chk(overflow == 1'b0, "R5 no drop below depth", int'(overflow), 0);

        // R7: disabled capture writes nothing
        rx_n = 0;
        drive_codes(300, 50);
        repeat (20) @(negedge smp_clk);
        chk(rx_n == 0, "R7 no words while disabled", rx_n, 0);
        chk(bus_valid == 1'b0, "R7 valid low", int'(bus_valid), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule